// File: doc/BRIEF.md
# Wide Search Command Issuer

This block sits on the host side of a cascaded ternary search engine. It takes a single request for a 272-bit search and turns it into the four-beat command burst that the engine expects. Each request carries a 272-bit key, two mask-pair indices, a 2-bit tag and a 3-bit result-slot index. The first mask-pair index covers the upper half of the key and the second covers the lower half. A hitting device returns the tag on its top two result-address bits. The slot index picks one of eight result registers in the engine.

Requests arrive over a valid/ready handshake. Once a request is taken, the issuer drives four consecutive beats, called A, B, C and D. In every beat the command strobe is high and the opcode field holds the search code. The key goes out on the 68-bit data bus one quarter per beat, most significant quarter first. Side-band fields ride on the shared upper command bits, and which fields appear depends on the beat. Bits that mean nothing in a beat are driven to zero. The issuer raises ready again in beat D, so waiting requests follow each other with no idle cycle between bursts. All outputs are registered.

Top module: `wide_search_issuer`

## Requirements
- R1: While a burst is in progress, cmd_valid is 1 in four consecutive cycles, and cmd_bus[1:0] equals 2'b10 in each of them.
- R2: cmd_data carries req_key[271:204] in beat A, [203:136] in beat B, [135:68] in beat C and [67:0] in beat D.
- R3: In beat A, cmd_bus[2] is 1 and cmd_bus[5:3] equals the upper-half mask index. cmd_bus[8:6] are 0.
- R4: In beat B, cmd_bus[8:2] are all 0.
- R5: In beat C, cmd_bus[2] is 0, cmd_bus[5:3] equals the lower-half mask index, cmd_bus[8:7] equals the hit tag and cmd_bus[6] is 0.
- R6: In beat D, cmd_bus[8:6] equals the result-slot index and cmd_bus[5:2] are 0.
- R7: When no burst is in progress, cmd_valid, cmd_bus and cmd_data are all 0.
- R8: req_ready is 1 when the block is idle and during beat D, and 0 during beats A to C. A request taken with req_valid and req_ready both high produces beat A in the next cycle, so bursts can run back to back.
- R9: A request presented while req_ready is 0 is ignored. The running burst keeps its own key and fields, and no extra burst follows.
- R10: While rst is high (synchronous, active high), an ongoing burst is abandoned. In the cycle after the reset edge, all outputs are 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Issuer can take a request this cycle |
| req_key | input | 272 | Search key |
| req_mask_hi | input | 3 | Mask-pair index for key bits [271:136] |
| req_mask_lo | input | 3 | Mask-pair index for key bits [135:0] |
| req_tag | input | 2 | Bits returned on result-address [21:20] on a hit |
| req_slot | input | 3 | Result register index |
| cmd_valid | output | 1 | Command strobe |
| cmd_bus | output | 9 | Command bus: opcode and per-beat fields |
| cmd_data | output | 68 | Key quarter for the current beat |

## Verification
A table of five requests runs back to back. Several keys give each quarter a distinct value, which exposes swapped or misordered slices. One key is all ones and another all zeros, which exposes stray zeroing or leaking of side fields into unused bits. The mask indices, tags and slots differ from each other within each request, so any field placed on the wrong bits or in the wrong beat gives a visible mismatch. Directed cases present a competing request while ready is low, and apply reset in the middle of a burst.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
  // Opcode field of the command bus
  localparam int          OPC_LSB    = 0;
  localparam int          OPC_W      = 2;
  localparam logic [1:0]  OPC_SEARCH = 2'b10;
  // Wide-search flag and mask-index field positions
  localparam int          WIDE_BIT   = 2;
  localparam int          MASK_LSB   = 3;
  // Bits cleared in beat D (flag plus mask field)
  localparam int          QUIET_D_LSB = 2;
  localparam int          QUIET_D_MSB = 5;
endpackage

// File: rtl/wsi_seq.sv
module wsi_seq #(
  parameter int BEATS = 4,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          accept,
  output logic          nxt_act,
  output logic [BW-1:0] nxt_beat
);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic          act_q;
  logic [BW-1:0] beat_q;

  assign req_ready = !act_q || (beat_q == LAST);
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (accept) begin
      nxt_act  = 1'b1;
      nxt_beat = '0;
    end else if (act_q && beat_q != LAST) begin
      nxt_act  = 1'b1;
      nxt_beat = beat_q + 1'b1;
    end else begin
      nxt_act  = 1'b0;
      nxt_beat = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      beat_q <= '0;
    end else begin
      act_q  <= nxt_act;
      beat_q <= nxt_beat;
    end
  end
endmodule

// File: rtl/wsi_req_hold.sv
module wsi_req_hold #(
  parameter int KEY_W  = 272,
  parameter int MIDX_W = 3,
  parameter int TAG_W  = 2,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [MIDX_W-1:0] in_mhi,
  input  logic [MIDX_W-1:0] in_mlo,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [SLOT_W-1:0] in_slot,
  output logic [KEY_W-1:0]  nx_key,
  output logic [MIDX_W-1:0] nx_mhi,
  output logic [MIDX_W-1:0] nx_mlo,
  output logic [TAG_W-1:0]  nx_tag,
  output logic [SLOT_W-1:0] nx_slot
);
  logic [KEY_W-1:0]  key_q;
  logic [MIDX_W-1:0] mhi_q, mlo_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SLOT_W-1:0] slot_q;

  // Fields seen by the formatter for the coming cycle
  assign nx_key  = accept ? in_key  : key_q;
  assign nx_mhi  = accept ? in_mhi  : mhi_q;
  assign nx_mlo  = accept ? in_mlo  : mlo_q;
  assign nx_tag  = accept ? in_tag  : tag_q;
  assign nx_slot = accept ? in_slot : slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      mhi_q  <= '0;
      mlo_q  <= '0;
      tag_q  <= '0;
      slot_q <= '0;
    end else begin
      key_q  <= nx_key;
      mhi_q  <= nx_mhi;
      mlo_q  <= nx_mlo;
      tag_q  <= nx_tag;
      slot_q <= nx_slot;
    end
  end
endmodule

// File: rtl/wsi_beat_fmt.sv
module wsi_beat_fmt
  import wsi_pkg::*;
#(
  parameter int KEY_W  = 272,
  parameter int LANE_W = 68,
  parameter int CMD_W  = 9,
  parameter int MIDX_W = 3,
  parameter int TAG_W  = 2,
  parameter int SLOT_W = 3,
  localparam int BEATS = KEY_W / LANE_W,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              act,
  input  logic [BW-1:0]     beat,
  input  logic [KEY_W-1:0]  key,
  input  logic [MIDX_W-1:0] mhi,
  input  logic [MIDX_W-1:0] mlo,
  input  logic [TAG_W-1:0]  tag,
  input  logic [SLOT_W-1:0] slot,
  output logic [CMD_W-1:0]  cmd,
  output logic [LANE_W-1:0] data
);
  localparam logic [BW-1:0] BEAT_A = '0;
  localparam logic [BW-1:0] BEAT_C = BW'(BEATS / 2);
  localparam logic [BW-1:0] BEAT_D = BW'(BEATS - 1);

  logic [LANE_W-1:0] lane [BEATS];

  // Most significant quarter goes out first
  for (genvar b = 0; b < BEATS; b++) begin : g_lane
    assign lane[b] = key[KEY_W-1-b*LANE_W -: LANE_W];
  end

  always_comb begin
    cmd  = '0;
    data = '0;
    if (act) begin
      data = lane[beat];
      cmd[OPC_LSB +: OPC_W] = OPC_SEARCH;
      if (beat == BEAT_A) begin
        cmd[WIDE_BIT]              = 1'b1;
        cmd[MASK_LSB +: MIDX_W]    = mhi;
      end else if (beat == BEAT_C) begin
        cmd[WIDE_BIT]              = 1'b0;
        cmd[MASK_LSB +: MIDX_W]    = mlo;
        cmd[CMD_W-1 -: TAG_W]      = tag;
      end else if (beat == BEAT_D) begin
        cmd[CMD_W-1 -: SLOT_W]     = slot;
      end
    end
  end
endmodule

// File: rtl/wide_search_issuer.sv
module wide_search_issuer #(
  parameter int KEY_W  = 272,
  parameter int LANE_W = 68,
  parameter int CMD_W  = 9,
  parameter int MIDX_W = 3,
  parameter int TAG_W  = 2,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KEY_W-1:0]  req_key,
  input  logic [MIDX_W-1:0] req_mask_hi,
  input  logic [MIDX_W-1:0] req_mask_lo,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [SLOT_W-1:0] req_slot,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_bus,
  output logic [LANE_W-1:0] cmd_data
);
  localparam int BEATS = KEY_W / LANE_W;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              accept, nxt_act;
  logic [BW-1:0]     nxt_beat;
  logic [KEY_W-1:0]  nx_key;
  logic [MIDX_W-1:0] nx_mhi, nx_mlo;
  logic [TAG_W-1:0]  nx_tag;
  logic [SLOT_W-1:0] nx_slot;
  logic [CMD_W-1:0]  fmt_cmd;
  logic [LANE_W-1:0] fmt_data;

  wsi_seq #(.BEATS(BEATS)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .nxt_act(nxt_act), .nxt_beat(nxt_beat)
  );

  wsi_req_hold #(.KEY_W(KEY_W), .MIDX_W(MIDX_W), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_hold (
    .clk(clk), .rst(rst), .accept(accept),
    .in_key(req_key), .in_mhi(req_mask_hi), .in_mlo(req_mask_lo),
    .in_tag(req_tag), .in_slot(req_slot),
    .nx_key(nx_key), .nx_mhi(nx_mhi), .nx_mlo(nx_mlo),
    .nx_tag(nx_tag), .nx_slot(nx_slot)
  );

  wsi_beat_fmt #(.KEY_W(KEY_W), .LANE_W(LANE_W), .CMD_W(CMD_W), .MIDX_W(MIDX_W),
                 .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_fmt (
    .act(nxt_act), .beat(nxt_beat), .key(nx_key), .mhi(nx_mhi), .mlo(nx_mlo),
    .tag(nx_tag), .slot(nx_slot), .cmd(fmt_cmd), .data(fmt_data)
  );

  // Output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_bus   <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= nxt_act;
      cmd_bus   <= fmt_cmd;
      cmd_data  <= fmt_data;
    end
  end
endmodule

// File: rtl/wsi_checker.sv
module wsi_checker
  import wsi_pkg::*;
#(
  parameter int BEATS  = 4,
  parameter int CMD_W  = 9,
  parameter int LANE_W = 68
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_bus,
  input logic [LANE_W-1:0] cmd_data
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  logic          prev_v;
  logic [BW-1:0] prev_pos, pos;

  // Beat position reconstructed from the output strobe alone
  assign pos = (prev_v && prev_pos != LAST) ? prev_pos + 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_v   <= 1'b0;
      prev_pos <= '0;
    end else begin
      prev_v   <= cmd_valid;
      prev_pos <= cmd_valid ? pos : '0;
    end
  end

  a_r1_opcode: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_bus[OPC_LSB +: OPC_W] == OPC_SEARCH);
  a_r1_run: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && pos != LAST) |=> cmd_valid);
  a_r3_wide_flag: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_bus[WIDE_BIT] == (pos == '0));
  a_r4_beat_b_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && pos == BW'(1)) |-> cmd_bus[CMD_W-1:WIDE_BIT] == '0);
  a_r6_beat_d_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && pos == LAST) |-> cmd_bus[QUIET_D_MSB:QUIET_D_LSB] == '0);
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> (cmd_bus == '0 && cmd_data == '0));
  a_r8_ready_low: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && pos != LAST) |-> !req_ready);
  a_r8_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd_valid && pos == '0));
endmodule

bind wide_search_issuer wsi_checker #(.BEATS(KEY_W / LANE_W), .CMD_W(CMD_W), .LANE_W(LANE_W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_bus(cmd_bus), .cmd_data(cmd_data)
);

// File: tb/test_wide_search_issuer.sv
`timescale 1ns/1ps
module test_wide_search_issuer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [271:0] req_key = '0;
  logic [2:0]   req_mask_hi = '0, req_mask_lo = '0, req_slot = '0;
  logic [1:0]   req_tag = '0;
  logic         cmd_valid;
  logic [8:0]   cmd_bus;
  logic [67:0]  cmd_data;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  wide_search_issuer i_wide_search_issuer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_key(req_key), .req_mask_hi(req_mask_hi), .req_mask_lo(req_mask_lo),
    .req_tag(req_tag), .req_slot(req_slot),
    .cmd_valid(cmd_valid), .cmd_bus(cmd_bus), .cmd_data(cmd_data)
  );

  localparam int NV = 5;
  localparam logic [271:0] T_KEY [NV] = '{
    {68'h123456789ABCDEF01, 68'h2468ACE013579BDF2, 68'hF0E1D2C3B4A596873, 68'h0F1E2D3C4B5A69784},
    {272{1'b1}},
    {272{1'b0}},
    {34{8'hA5}},
    {68'h00000000000000001, 68'h80000000000000000, 68'hFFFFFFFFFFFFFFFFE, 68'h7FFFFFFFFFFFFFFFF}
  };
  localparam logic [2:0] T_MHI  [NV] = '{3'd5, 3'd7, 3'd0, 3'd2, 3'd6};
  localparam logic [2:0] T_MLO  [NV] = '{3'd3, 3'd0, 3'd7, 3'd4, 3'd1};
  localparam logic [1:0] T_TAG  [NV] = '{2'd2, 2'd1, 2'd3, 2'd0, 2'd2};
  localparam logic [2:0] T_SLOT [NV] = '{3'd6, 3'd4, 3'd5, 3'd1, 3'd7};

  task automatic chk(input string req, input logic [271:0] act, input logic [271:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_cmd(input int b, input int v);
    logic [8:0] c;
    c = '0;
    c[1:0] = 2'b10;
    case (b)
      0: begin c[2] = 1'b1; c[5:3] = T_MHI[v]; end
      2: begin c[5:3] = T_MLO[v]; c[8:7] = T_TAG[v]; end
      3: c[8:6] = T_SLOT[v];
      default: ;
    endcase
    return c;
  endfunction

  function automatic logic [67:0] exp_data(input int b, input int v);
    return T_KEY[v][271-68*b -: 68];
  endfunction

  task automatic drive_req(input int v);
    req_valid   = 1'b1;
    req_key     = T_KEY[v];
    req_mask_hi = T_MHI[v];
    req_mask_lo = T_MLO[v];
    req_tag     = T_TAG[v];
    req_slot    = T_SLOT[v];
  endtask

  task automatic check_beat(input int b, input int v);
    chk("R1 cmd_valid", 272'(cmd_valid), 272'(1));
    chk((b == 0) ? "R3 beat A bus" : (b == 1) ? "R4 beat B bus" :
        (b == 2) ? "R5 beat C bus" : "R6 beat D bus", 272'(cmd_bus), 272'(exp_cmd(b, v)));
    chk("R2 data slice", 272'(cmd_data), 272'(exp_data(b, v)));
    chk("R8 ready per beat", 272'(req_ready), 272'(b == 3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk("R10 reset cmd_valid", 272'(cmd_valid), 272'(0));
    chk("R7 idle bus", 272'(cmd_bus), 272'(0));
    chk("R7 idle data", 272'(cmd_data), 272'(0));
    chk("R8 idle ready", 272'(req_ready), 272'(1));

    // Table walk: back-to-back bursts
    for (int v = 0; v < NV; v++) begin
      drive_req(v);
      chk("R8 ready at take", 272'(req_ready), 272'(1));
      for (int b = 0; b < 4; b++) begin
        @(negedge clk);
        if (b == 0) begin
          req_valid = 1'b0;
          if (v == 1) begin
            // R9: competing request while ready is low
            req_valid   = 1'b1;
            req_key     = {17{16'hDEAD}};
            req_mask_hi = 3'd1;
            req_mask_lo = 3'd2;
            req_tag     = 2'd3;
            req_slot    = 3'd3;
          end
        end
        if (b == 2) req_valid = 1'b0;
        check_beat(b, v);
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R7 idle valid after run", 272'(cmd_valid), 272'(0));
    chk("R7 idle data after run", 272'(cmd_data), 272'(0));
    chk("R9 no extra burst", 272'(cmd_bus), 272'(0));
    chk("R8 ready idle", 272'(req_ready), 272'(1));

    // Idle gap then a lone burst
    repeat (2) @(negedge clk);
    drive_req(3);
    @(negedge clk);
    req_valid = 1'b0;
    check_beat(0, 3);
    @(negedge clk);
    check_beat(1, 3);
    // R10: reset mid-burst
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset valid", 272'(cmd_valid), 272'(0));
    chk("R10 reset bus", 272'(cmd_bus), 272'(0));
    chk("R10 reset data", 272'(cmd_data), 272'(0));
    chk("R10 reset ready", 272'(req_ready), 272'(1));
    rst = 1'b0;
    @(negedge clk);
    chk("R10 stays idle", 272'(cmd_valid), 272'(0));
    chk("R10 stays idle data", 272'(cmd_data), 272'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule